// File: doc/BRIEF.md
# Time-Slotted Port Bus Burst Engine

This block is the switch-side master of a shared, time-divided bus that serves up to sixteen Layer 2 port devices over one 32-bit bidirectional data path. Time on the bus is cut into fixed bus cycles of 48 clocks. Each cycle is one slot owned by a single port. An external arbiter names the owner of the following slot while the current slot is still running. During each slot the block moves at most one burst of sixteen words, in one direction only.

In a receive slot, words arriving from the port device come out on an internal stream with the port number, start-of-packet, end-of-packet, a valid-byte code and an error flag. A packet may span several slots. The device may abort the packet in progress. In a transmit slot, the block asks an internal source for words of the packet pending for that port and drives them onto the bus. It signals the final word and its valid bytes. A programmable sync output marks a chosen clock of every bus cycle.

Top module: `tdm_slot_port`

## Requirements
- R1: The bus cycle is 48 clocks long, counted 0 to 47 from reset. `sync` is high on exactly the clock whose count equals `sync_pos` and low on all other clocks.
- R2: `next_port` is sampled at count 2. The sampled value owns the whole next bus cycle, which is reported on `tx_port` and `rx_port`.
- R3: `rx_rdy_in`, `tx_rdy_in` and `tx_pend` are sampled at count 4 and decide the direction of the next slot. The slot transmits if the next owner's `tx_pend` bit and `tx_rdy_in` are both high. Otherwise it receives if `rx_rdy_in` is high. Otherwise it idles.
- R4: In a transmit slot, `tx_rdy_out` is high on counts 11 through 29 and low on all others. It is low in every receive or idle slot.
- R5: In a transmit slot, data beats fall on counts 12 to 27. On each beat still open, `tx_ready` is high and `l2_data` carries `tx_data` in the same clock.
- R6: The transmit beat with `tx_eop` high drives `l2_last_word` high and puts `tx_bytes` on `l2_last_byte`. No further beat of that slot is taken, and the block leaves the data lines undriven for the rest of it.
- R7: In a receive slot, the words on `l2_data` at counts 12 to 27 appear on `rx_data` one clock later, with `rx_valid` high and `rx_port` set to the owner. `rx_bytes` is 11 on every word that does not end the packet.
- R8: A received word with `l2_last_word` high ends the packet. `rx_eop` is 1 and `rx_bytes` copies `l2_last_byte`, where 00, 01, 10 and 11 mean 1, 2, 3 and 4 valid bytes filled from bits 31:24 downward. Later beats of that slot are ignored. `rx_sop` is 1 on the first word of each port's next packet and 0 on its following words, kept per port across slots.
- R9: `abort_in` is accepted in a receive slot at counts 12 to 47 while the packet is still open. If it arrives on a beat, that word is reported with `rx_eop` and `rx_err` high and `rx_bytes` 11, overriding the last-word pins. If it arrives after the beats, a word of zero data with the same flags is reported one clock later. An abort before count 12, after the packet has ended, or in a non-receive slot has no effect.
- R10: An idle slot produces no `rx_valid`, no `tx_ready` and no `tx_rdy_out`, and the block never drives `l2_data` in it. During reset all of these outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pos | input | $clog2(CYC) | Count at which sync is raised |
| sync | output | 1 | Bus-cycle marker |
| next_port | input | $clog2(PORTS) | Owner of the next slot, from the arbiter |
| rx_rdy_in | input | 1 | Device has data for the next slot |
| tx_rdy_in | input | 1 | Device can accept data in the next slot |
| tx_rdy_out | output | 1 | Data is offered to the device in this slot |
| abort_in | input | 1 | Receive abort pulse |
| l2_data | inout | DW | Shared bus data |
| l2_last_word | inout | 1 | Final word of a packet |
| l2_last_byte | inout | 2 | Valid-byte code of the final word |
| tx_pend | input | PORTS | Per-port packet-pending flags from the source |
| tx_data | input | DW | Transmit word from the source |
| tx_eop | input | 1 | Current transmit word ends the packet |
| tx_bytes | input | 2 | Valid-byte code of the final transmit word |
| tx_ready | output | 1 | Current transmit word is taken this clock |
| tx_port | output | $clog2(PORTS) | Owner of the current slot |
| rx_valid | output | 1 | Received word valid |
| rx_data | output | DW | Received word |
| rx_port | output | $clog2(PORTS) | Port of the received word |
| rx_sop | output | 1 | First word of a packet |
| rx_eop | output | 1 | Last word of a packet |
| rx_bytes | output | 2 | Valid-byte code of the received word |
| rx_err | output | 1 | Packet ended by abort |

## Verification
The bench builds the block with PORTS set to 4, so a two-bit port number lets a short run give every port receive and transmit slots. The slot timing parameters keep their defaults, so the checks on counts 2, 4, 11, 12, 27, 29, 30 and 47 land on the real slot boundaries. The small port count makes room to sweep the end-of-packet beat over all sixteen positions with all four byte codes in both directions, and to step `sync_pos` through all 48 counts. It also covers abort positions before, during and after the beats, multi-slot packets on interleaved ports, and every arm of the direction choice.

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
  parameter int PORTS   = 16,
  parameter int DW      = 32,
  parameter int CYC     = 48,
  parameter int BEATS   = 16,
  parameter int BEAT0   = 12,
  parameter int NXT_AT  = 2,
  parameter int RDY_AT  = 4,
  parameter int TXR_ON  = 11,
  parameter int TXR_OFF = 30,
  localparam int PW     = $clog2(PORTS),
  localparam int CW     = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] sync_pos,
  output logic          sync,
  input  logic [PW-1:0] next_port,
  input  logic          rx_rdy_in,
  input  logic          tx_rdy_in,
  output logic          tx_rdy_out,
  input  logic          abort_in,
  inout  wire  [DW-1:0] l2_data,
  inout  wire           l2_last_word,
  inout  wire  [1:0]    l2_last_byte,
  input  logic [PORTS-1:0] tx_pend,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_eop,
  input  logic [1:0]    tx_bytes,
  output logic          tx_ready,
  output logic [PW-1:0] tx_port,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic [PW-1:0] rx_port,
  output logic          rx_sop,
  output logic          rx_eop,
  output logic [1:0]    rx_bytes,
  output logic          rx_err
);
  localparam logic [CW-1:0] C_LAST = CW'(CYC - 1);
  localparam logic [CW-1:0] C_NXT  = CW'(NXT_AT);
  localparam logic [CW-1:0] C_RDY  = CW'(RDY_AT);
  localparam logic [CW-1:0] C_B0   = CW'(BEAT0);
  localparam logic [CW-1:0] C_BEND = CW'(BEAT0 + BEATS);
  localparam logic [CW-1:0] C_TON  = CW'(TXR_ON);
  localparam logic [CW-1:0] C_TOFF = CW'(TXR_OFF);

  typedef enum logic [1:0] {D_IDLE, D_RX, D_TX} dir_t;

  logic [CW-1:0]    cnt;
  logic [PW-1:0]    nxt_port, cur_port;
  dir_t             nxt_dir, cur_dir;
  logic             done;
  logic [PORTS-1:0] sop_pend;

  wire beat_win  = (cnt >= C_B0) && (cnt < C_BEND);
  wire tx_go     = (cur_dir == D_TX) && !done && beat_win;
  wire rx_take   = (cur_dir == D_RX) && !done && beat_win;
  wire abort_hit = (cur_dir == D_RX) && !done && (cnt >= C_B0) && abort_in;
  wire rx_hit    = rx_take || abort_hit;
  wire rx_end    = abort_hit || (rx_take && l2_last_word);

  assign sync         = (cnt == sync_pos);
  assign tx_rdy_out   = (cur_dir == D_TX) && (cnt >= C_TON) && (cnt < C_TOFF);
  assign tx_ready     = tx_go;
  assign tx_port      = cur_port;
  assign l2_data      = tx_go ? tx_data : {DW{1'bz}};
  assign l2_last_word = tx_go ? tx_eop : 1'bz;
  assign l2_last_byte = tx_go ? (tx_eop ? tx_bytes : 2'b11) : 2'bzz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      nxt_port <= '0;
      cur_port <= '0;
      nxt_dir  <= D_IDLE;
      cur_dir  <= D_IDLE;
      done     <= 1'b0;
      sop_pend <= '1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_port  <= '0;
      rx_sop   <= 1'b0;
      rx_eop   <= 1'b0;
      rx_bytes <= 2'b00;
      rx_err   <= 1'b0;
    end else begin
      cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
      if (cnt == C_NXT) nxt_port <= next_port;
      if (cnt == C_RDY)
        nxt_dir <= (tx_pend[nxt_port] && tx_rdy_in) ? D_TX :
                   rx_rdy_in ? D_RX : D_IDLE;
      if (cnt == C_LAST) begin
        cur_port <= nxt_port;
        cur_dir  <= nxt_dir;
        done     <= 1'b0;
      end else if ((rx_hit && rx_end) || (tx_go && tx_eop)) begin
        done <= 1'b1;
      end
      rx_valid <= rx_hit;
      if (rx_hit) begin
        rx_data  <= rx_take ? l2_data : '0;
        rx_port  <= cur_port;
        rx_sop   <= sop_pend[cur_port];
        rx_eop   <= rx_end;
        rx_bytes <= (rx_take && !abort_in && l2_last_word) ? l2_last_byte : 2'b11;
        rx_err   <= abort_hit;
        sop_pend[cur_port] <= rx_end;
      end
    end
  end

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == C_LAST |=> cnt == '0);
  // R1
  sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);
  // R4
  txr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy_out) |-> cnt == C_TON);
  // R5
  beat_in_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_rdy_out);
  // R6
  tx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_eop) |=> !tx_ready);
  // R9
  err_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err) |-> rx_eop);
  // R7
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !rx_valid);
endmodule

// File: tb/tb_tdm_slot_port.sv
module tb_tdm_slot_port;
  localparam int NP = 4;
  localparam int D_IDLE = 0, D_RX = 1, D_TX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] sync_pos = '0;
  logic sync;
  logic [1:0] next_port = '0;
  logic rx_rdy_in = 0, tx_rdy_in = 0, abort_in = 0;
  logic tx_rdy_out;
  wire [31:0] l2_data;
  wire l2_last_word;
  wire [1:0] l2_last_byte;
  logic [NP-1:0] tx_pend = '0;
  logic [31:0] tx_data = '0;
  logic tx_eop = 0;
  logic [1:0] tx_bytes = '0;
  logic tx_ready;
  logic [1:0] tx_port;
  logic rx_valid, rx_sop, rx_eop, rx_err;
  logic [31:0] rx_data;
  logic [1:0] rx_port, rx_bytes;

  logic b_en = 0;
  logic [31:0] b_d = '0;
  logic b_lw = 0;
  logic [1:0] b_lb = '0;
  assign l2_data      = b_en ? b_d : 32'hz;
  assign l2_last_word = b_en ? b_lw : 1'bz;
  assign l2_last_byte = b_en ? b_lb : 2'bzz;

  int total = 0, bad = 0;
  int cdir = D_IDLE, cport = 0;
  bit sopx [NP];

  always #5 clk = ~clk;

  tdm_slot_port #(.PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .sync_pos(sync_pos), .sync(sync),
    .next_port(next_port), .rx_rdy_in(rx_rdy_in), .tx_rdy_in(tx_rdy_in),
    .tx_rdy_out(tx_rdy_out), .abort_in(abort_in), .l2_data(l2_data),
    .l2_last_word(l2_last_word), .l2_last_byte(l2_last_byte),
    .tx_pend(tx_pend), .tx_data(tx_data), .tx_eop(tx_eop), .tx_bytes(tx_bytes),
    .tx_ready(tx_ready), .tx_port(tx_port), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_port(rx_port), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_bytes(rx_bytes), .rx_err(rx_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] tpat(int p, int b);
    return 32'hA000_0000 | (p << 16) | (b & 16'hFFFF);
  endfunction
  function automatic logic [31:0] rpat(int p, int b);
    return 32'h5000_0000 | (p << 16) | (b & 16'hFFFF);
  endfunction

  // One bus cycle; eop/lb/abt stimulate the current slot, np/rr/tr/pend pick the next.
  task automatic slot(input int np, input bit rr, input bit tr, input logic [NP-1:0] pend,
                      input int eop, input int lb, input int abt, input int sp);
    bit topen = 1, ropen = 1, ev = 0, eeop = 0, eerr = 0, esop = 0;
    logic [31:0] ed = '0;
    logic [1:0] eb = '0;
    for (int k = 0; k < 48; k++) begin
      int beat = k - 12;
      bit inw = (k >= 12) && (k < 28);
      bit txon = (cdir == D_TX) && topen && inw;
      sync_pos = 6'(sp);
      next_port = 2'(np);
      rx_rdy_in = rr; tx_rdy_in = tr; tx_pend = pend;
      abort_in = (k == abt);
      tx_data = tpat(cport, beat);
      tx_eop = inw && (beat == eop);
      tx_bytes = 2'(lb);
      b_en = inw && !txon;
      b_d = (cdir == D_RX) ? rpat(cport, beat) : (32'hC3C3_0000 | k);
      b_lw = (cdir == D_RX) && (eop >= 0) && (beat >= eop);
      b_lb = 2'(lb);
      #1;
      chk(sync == (k == sp), "R1", "sync", {31'd0, sync}, {31'd0, k == sp});
      chk(tx_rdy_out == ((cdir == D_TX) && k >= 11 && k < 30), "R4", "tx_rdy_out",
          {31'd0, tx_rdy_out}, {31'd0, (cdir == D_TX) && k >= 11 && k < 30});
      chk(tx_ready == txon, (cdir == D_IDLE) ? "R10" : "R5", "tx_ready",
          {31'd0, tx_ready}, {31'd0, txon});
      chk(rx_valid == ev, (cdir == D_IDLE) ? "R10" : "R7", "rx_valid",
          {31'd0, rx_valid}, {31'd0, ev});
      if (ev) begin
        chk(rx_data == ed, "R7", "rx_data", rx_data, ed);
        chk(rx_port == 2'(cport), "R2", "rx_port", {30'd0, rx_port}, cport);
        chk(rx_eop == eeop, "R8", "rx_eop", {31'd0, rx_eop}, {31'd0, eeop});
        chk(rx_bytes == eb, "R8", "rx_bytes", {30'd0, rx_bytes}, {30'd0, eb});
        chk(rx_err == eerr, "R9", "rx_err", {31'd0, rx_err}, {31'd0, eerr});
        chk(rx_sop == esop, "R8", "rx_sop", {31'd0, rx_sop}, {31'd0, esop});
      end
      if (txon) begin
        chk(l2_data == tpat(cport, beat), "R5", "l2_data", l2_data, tpat(cport, beat));
        chk(tx_port == 2'(cport), "R2", "tx_port", {30'd0, tx_port}, cport);
        chk(l2_last_word == (beat == eop), "R6", "l2_last_word",
            {31'd0, l2_last_word}, {31'd0, beat == eop});
        if (beat == eop) chk(l2_last_byte == 2'(lb), "R6", "l2_last_byte",
                             {30'd0, l2_last_byte}, lb);
      end
      if (b_en) chk(l2_data == b_d, (cdir == D_TX) ? "R6" : "R10", "bus readback", l2_data, b_d);
      ev = 0;
      if (cdir == D_RX && ropen && inw) begin
        ev = 1; ed = rpat(cport, beat); esop = sopx[cport];
        if (k == abt) begin eeop = 1; eerr = 1; eb = 2'b11; end
        else if (beat == eop) begin eeop = 1; eerr = 0; eb = 2'(lb); end
        else begin eeop = 0; eerr = 0; eb = 2'b11; end
      end else if (cdir == D_RX && ropen && k >= 12 && k == abt) begin
        ev = 1; ed = '0; esop = sopx[cport]; eeop = 1; eerr = 1; eb = 2'b11;
      end
      if (ev) begin
        sopx[cport] = eeop;
        if (eeop) ropen = 0;
      end
      if (txon && beat == eop) topen = 0;
      @(negedge clk);
    end
    cdir = (pend[np] && tr) ? D_TX : (rr ? D_RX : D_IDLE);
    cport = np;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) sopx[p] = 1;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk(!rx_valid && !tx_ready && !tx_rdy_out, "R10", "reset outputs",
        {29'd0, rx_valid, tx_ready, tx_rdy_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    slot(0, 1, 0, '0, -1, 0, -1, 0);
    // R7 R8: receive end beat over all 16 positions and all byte codes
    for (int i = 0; i < 16; i++) slot((i + 1) % NP, 1, 0, '0, i, i % 4, -1, i);
    slot(2, 1, 0, '0, 3, 2, 8, 0);    // R9 early abort ignored
    slot(1, 1, 0, '0, -1, 0, -1, 0);  // R8 port 2 packet continues
    slot(2, 1, 0, '0, 0, 3, -1, 0);   // port 1 one-word packet
    slot(3, 1, 0, '0, 5, 1, -1, 0);   // port 2 resumes without sop
    slot(0, 1, 0, '0, 10, 0, 14, 0);  // R9 abort on a beat
    slot(0, 1, 0, '0, -1, 0, 35, 0);  // R9 abort after the beats
    slot(3, 1, 0, '0, 4, 1, 20, 0);   // R9 abort after end ignored
    slot(0, 0, 1, 4'b0001, 6, 2, -1, 0);
    // R5 R6: transmit end beat sweep
    for (int i = 0; i < 16; i++) slot((i + 1) % NP, 0, 1, 4'hF, i, i % 4, -1, 0);
    slot(0, 0, 1, 4'hF, -1, 0, -1, 0);        // full burst, no end
    slot(1, 1, 1, 4'b0010, 7, 1, -1, 0);      // R3 transmit wins over receive
    slot(2, 1, 1, 4'b0010, 15, 3, -1, 0);     // R3 not pending -> receive
    slot(3, 1, 0, 4'b1000, 1, 0, -1, 0);      // R3 device not ready -> receive
    slot(1, 0, 1, 4'b0001, 2, 2, -1, 0);      // R3 -> idle
    slot(0, 0, 0, '0, -1, 0, 20, 0);          // R10 idle slot with abort
    // R1 sync position sweep
    for (int s = 0; s < 48; s++) slot(0, 0, 0, '0, -1, 0, -1, s);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule